// File: doc/BRIEF.md
# Serial Radio Configuration Register Port

This block is the write-only configuration entry point of a radio control core. A host frames each transfer with an active-low select line and clocks data in on a serial clock. Each 16-bit word carries a 4-bit address in its upper bits and a 12-bit payload in its lower bits. When the select line returns high, the payload lands in the register named by the address. The registers drive the core's settings: a block enable mask, synthesizer settings, an RF channel number with its carrier frequency in MHz, receiver settings and a power amplifier bias code.

The three serial lines are brought into the system clock domain through a synchronizer, and all edge detection happens there. The port never counts clocks. Only the final 16 bits before the select line rises are committed, however many bits were shifted. A system reset loads a defined default into every register. The shutdown input gates only the enable mask seen by the radio. Register contents survive shutdown, and the port keeps accepting writes while it is asserted.

Top module: `radio_cfg_port`

## Requirements
- R1: After reset the outputs show the defaults: enable mask 0x0F3, synthesizer 0x041, channel 37 (carrier 2437 MHz), receiver 0x2A4, bias code 8.
- R2: Bits shift in most significant bit first, one bit on each rising serial clock while select is low. Bit 15 is the first bit sent. Bits 15..12 form the address and bits 11..0 form the payload. Serial clock edges while select is high shift nothing.
- R3: A rising edge on select writes the payload into the addressed register: address 1 is the enable mask, 2 the synthesizer, 3 the channel, 4 the receiver and 5 the transmit settings. Registers change only on such an edge, and each edge writes exactly once.
- R4: When more than 16 bits are clocked in one frame, only the last 16 are committed.
- R5: A word whose address is 0, or 6 through 15, changes no register.
- R6: A channel payload above 99 is stored as 99. The carrier output always equals 2400 plus the stored channel.
- R7: While shutdown is asserted (low), the enable mask output reads zero. Every register keeps its contents, and writes still complete. When shutdown is released, the enable mask output again shows the register's value.
- R8: The bias code output is bits 3..0 of the last payload written to address 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; loads defaults |
| shdn_n | input | 1 | Active-low shutdown |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| en_mask_o | output | 12 | Block enable mask, zero in shutdown |
| synth_o | output | 12 | Synthesizer settings |
| chan_o | output | 7 | Channel number 0..99 |
| chan_mhz_o | output | 12 | Carrier frequency in MHz |
| rx_cfg_o | output | 12 | Receiver settings |
| pa_bias_o | output | 4 | Power amplifier bias code |

## Verification
Two functions can act in the same system cycle: a register commit, and the release of shutdown that re-exposes the enable mask. The bench writes a new mask during shutdown. It raises select, then releases shutdown two system clocks later, so that the first enabled cycle is the cycle in which the synchronized select edge commits. It then requires the mask output to show the newly written value, and neither zero nor the previous mask. Before the release, the bench also requires that the mask output stayed zero while the write was in flight.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 12;
   localparam int CHAN_W = 7;
   localparam int BIAS_W = 4;
   localparam int FREQ_W = 12;

   // address map
   localparam int ADR_ENABLE = 1;
   localparam int ADR_SYNTH  = 2;
   localparam int ADR_CHAN   = 3;
   localparam int ADR_RX     = 4;
   localparam int ADR_TX     = 5;

   // power-up values
   localparam logic [DATA_W-1:0] DEF_ENABLE = 12'h0F3;
   localparam logic [DATA_W-1:0] DEF_SYNTH  = 12'h041;
   localparam logic [DATA_W-1:0] DEF_RX     = 12'h2A4;
   localparam logic [BIAS_W-1:0] DEF_BIAS   = 4'h8;
   localparam int                DEF_CHAN   = 37;
   localparam int                CHAN_MAX   = 99;
   localparam int                BASE_MHZ   = 2400;
endpackage

// File: rtl/rcfg_sync.sv
module rcfg_sync #(
   parameter int               W       = 3,
   parameter int               STAGES  = 2,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rcfg_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d_i;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rcfg_shift.sv
module rcfg_shift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_i,
   input  logic         bit_i,
   output logic [W-1:0] word_o
);
   generate
      if (W < 2) begin : g_bad_w
         $error("rcfg_shift width too small");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       word_o <= '0;
      else if (shift_i) word_o <= {word_o[W-2:0], bit_i};
   end

   // R2: without a serial clock edge the capture word holds
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_i |=> $stable(word_o));
   // R2: newest bit enters at the least significant end
   p_lsb_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i |=> (word_o[0] == $past(bit_i)));
endmodule

// File: rtl/rcfg_regbank.sv
module rcfg_regbank #(
   parameter int                ADDR_W     = rcfg_pkg::ADDR_W,
   parameter int                DATA_W     = rcfg_pkg::DATA_W,
   parameter int                CHAN_W     = rcfg_pkg::CHAN_W,
   parameter int                BIAS_W     = rcfg_pkg::BIAS_W,
   parameter int                CHAN_MAX   = rcfg_pkg::CHAN_MAX,
   parameter int                CHAN_DEF   = rcfg_pkg::DEF_CHAN,
   parameter bit                CHAN_CLAMP = 1'b1,
   parameter logic [DATA_W-1:0] EN_DEF     = rcfg_pkg::DEF_ENABLE,
   parameter logic [DATA_W-1:0] SYN_DEF    = rcfg_pkg::DEF_SYNTH,
   parameter logic [DATA_W-1:0] RX_DEF     = rcfg_pkg::DEF_RX,
   parameter logic [BIAS_W-1:0] BIAS_DEF   = rcfg_pkg::DEF_BIAS,
   localparam int               WORD_W     = ADDR_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [DATA_W-1:0] en_q,
   output logic [DATA_W-1:0] syn_q,
   output logic [CHAN_W-1:0] chan_q,
   output logic [DATA_W-1:0] rx_q,
   output logic [BIAS_W-1:0] bias_q
);
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] data;
   logic              mapped;
   logic              chan_ok;
   logic [CHAN_W-1:0] chan_val;

   assign addr = word_i[WORD_W-1:DATA_W];
   assign data = word_i[DATA_W-1:0];

   always_comb begin
      unique case (addr)
         ADDR_W'(rcfg_pkg::ADR_ENABLE), ADDR_W'(rcfg_pkg::ADR_SYNTH),
         ADDR_W'(rcfg_pkg::ADR_CHAN),   ADDR_W'(rcfg_pkg::ADR_RX),
         ADDR_W'(rcfg_pkg::ADR_TX):     mapped = 1'b1;
         default:                       mapped = 1'b0;
      endcase
   end

   // out-of-range channel handling: saturate or drop
   generate
      if (CHAN_CLAMP) begin : g_clamp
         always_comb begin
            chan_ok  = 1'b1;
            chan_val = (data > DATA_W'(CHAN_MAX)) ? CHAN_W'(CHAN_MAX)
                                                  : data[CHAN_W-1:0];
         end
      end else begin : g_reject
         always_comb begin
            chan_ok  = (data <= DATA_W'(CHAN_MAX));
            chan_val = data[CHAN_W-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= EN_DEF;
         syn_q  <= SYN_DEF;
         chan_q <= CHAN_W'(CHAN_DEF);
         rx_q   <= RX_DEF;
         bias_q <= BIAS_DEF;
      end else if (wr_i) begin
         case (addr)
            ADDR_W'(rcfg_pkg::ADR_ENABLE): en_q  <= data;
            ADDR_W'(rcfg_pkg::ADR_SYNTH):  syn_q <= data;
            ADDR_W'(rcfg_pkg::ADR_CHAN):   if (chan_ok) chan_q <= chan_val;
            ADDR_W'(rcfg_pkg::ADR_RX):     rx_q  <= data;
            ADDR_W'(rcfg_pkg::ADR_TX):     bias_q <= data[BIAS_W-1:0];
            default: ;
         endcase
      end
   end

   // R3: no commit, no change
   p_hold_no_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> ($stable(en_q) && $stable(syn_q) && $stable(chan_q)
                 && $stable(rx_q) && $stable(bias_q)));
   // R5: unassigned address leaves the bank alone
   p_unmapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !mapped) |=> ($stable(en_q) && $stable(syn_q) && $stable(chan_q)
                             && $stable(rx_q) && $stable(bias_q)));
   // R6: stored channel stays inside the band
   p_chan_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chan_q <= CHAN_W'(CHAN_MAX));
   // R8: bias code follows a transmit-settings write
   p_bias_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr == ADDR_W'(rcfg_pkg::ADR_TX))
         |=> (bias_q == $past(word_i[BIAS_W-1:0])));
endmodule

// File: rtl/radio_cfg_port.sv
module radio_cfg_port #(
   parameter int  SYNC_STAGES = 2,
   parameter bit  CHAN_CLAMP  = 1'b1,
   parameter int  ADDR_W      = rcfg_pkg::ADDR_W,
   parameter int  DATA_W      = rcfg_pkg::DATA_W,
   parameter int  CHAN_W      = rcfg_pkg::CHAN_W,
   parameter int  BIAS_W      = rcfg_pkg::BIAS_W,
   parameter int  FREQ_W      = rcfg_pkg::FREQ_W,
   parameter int  CHAN_MAX    = rcfg_pkg::CHAN_MAX,
   parameter int  CHAN_DEF    = rcfg_pkg::DEF_CHAN,
   parameter int  BASE_MHZ    = rcfg_pkg::BASE_MHZ
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shdn_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic [DATA_W-1:0] en_mask_o,
   output logic [DATA_W-1:0] synth_o,
   output logic [CHAN_W-1:0] chan_o,
   output logic [FREQ_W-1:0] chan_mhz_o,
   output logic [DATA_W-1:0] rx_cfg_o,
   output logic [BIAS_W-1:0] pa_bias_o
);
   localparam int WORD_W = ADDR_W + DATA_W;

   generate
      if (CHAN_DEF > CHAN_MAX) begin : g_bad_def
         $error("default channel outside range");
      end
      if ((1 << CHAN_W) <= CHAN_MAX) begin : g_bad_chw
         $error("channel width too small");
      end
      if (BIAS_W > DATA_W) begin : g_bad_bias
         $error("bias code wider than payload");
      end
      if (BASE_MHZ + CHAN_MAX >= (1 << FREQ_W)) begin : g_bad_freq
         $error("frequency width too small");
      end
   endgenerate

   // synchronized lines: {select, clock, data}
   logic [2:0] lines_s;
   logic       cs_s, sclk_s, sdi_s;
   logic       cs_prev, sclk_prev;
   logic       shift_en, commit;
   logic [WORD_W-1:0] cap_word;
   logic [DATA_W-1:0] en_q;

   rcfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_i({cs_n, sclk, sdi}), .q_o(lines_s));

   assign {cs_s, sclk_s, sdi_s} = lines_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_prev   <= 1'b1;
         sclk_prev <= 1'b0;
      end else begin
         cs_prev   <= cs_s;
         sclk_prev <= sclk_s;
      end
   end

   assign shift_en = sclk_s & ~sclk_prev & ~cs_s;
   assign commit   = cs_s & ~cs_prev;

   rcfg_shift #(.W(WORD_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .shift_i(shift_en), .bit_i(sdi_s),
      .word_o(cap_word));

   rcfg_regbank #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAN_W(CHAN_W), .BIAS_W(BIAS_W),
      .CHAN_MAX(CHAN_MAX), .CHAN_DEF(CHAN_DEF), .CHAN_CLAMP(CHAN_CLAMP)
   ) i_bank (
      .clk(clk), .rst_n(rst_n), .wr_i(commit), .word_i(cap_word),
      .en_q(en_q), .syn_q(synth_o), .chan_q(chan_o), .rx_q(rx_cfg_o),
      .bias_q(pa_bias_o));

   assign en_mask_o  = shdn_n ? en_q : '0;
   assign chan_mhz_o = FREQ_W'(BASE_MHZ) + FREQ_W'(chan_o);

   // R3: one select rise gives a single-cycle commit
   p_single_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);
   // R2: nothing shifts on the cycle a frame closes
   p_no_shift_on_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !shift_en);
   // R7: shutdown without a commit keeps the settings
   p_shdn_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!shdn_n && !commit) |=> ($stable(chan_o) && $stable(synth_o)
                                && $stable(pa_bias_o)));
endmodule

// File: tb/test_radio_cfg_port.sv
module test_radio_cfg_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        shdn_n = 1'b1;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        sdi = 1'b0;
   logic [11:0] en_mask_o, synth_o, chan_mhz_o, rx_cfg_o;
   logic [6:0]  chan_o;
   logic [3:0]  pa_bias_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   radio_cfg_port i_radio_cfg_port (
      .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .cs_n(cs_n), .sclk(sclk),
      .sdi(sdi), .en_mask_o(en_mask_o), .synth_o(synth_o), .chan_o(chan_o),
      .chan_mhz_o(chan_mhz_o), .rx_cfg_o(rx_cfg_o), .pa_bias_o(pa_bias_o));

   task automatic chk(input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // shift n bits (MSB of the n-bit field first); optionally close frame
   task automatic ser_bits(input logic [31:0] v, input int n, input bit close);
      @(negedge clk) cs_n = 1'b0;
      wait_neg(4);
      for (int i = n - 1; i >= 0; i--) begin
         sdi  = v[i];
         sclk = 1'b0;
         wait_neg(4);
         sclk = 1'b1;
         wait_neg(4);
      end
      sclk = 1'b0;
      wait_neg(4);
      if (close) begin
         cs_n = 1'b1;
         wait_neg(8);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [11:0] d);
      ser_bits({16'h0, a, d}, 16, 1'b1);
   endtask

   task automatic t_reset;
      chk("R1 enable", en_mask_o, 12'h0F3);
      chk("R1 synth", synth_o, 12'h041);
      chk("R1 chan", chan_o, 37);
      chk("R1 mhz", chan_mhz_o, 2437);
      chk("R1 rx", rx_cfg_o, 12'h2A4);
      chk("R1 bias", pa_bias_o, 8);
   endtask

   task automatic t_basic;
      wr(4'h1, 12'h5A6);
      chk("R3 enable", en_mask_o, 12'h5A6);
      wr(4'h2, 12'hC3E);
      chk("R3 synth", synth_o, 12'hC3E);
      wr(4'h3, 12'd11);
      chk("R2 chan", chan_o, 11);
      chk("R6 mhz", chan_mhz_o, 2411);
      wr(4'h4, 12'h801);
      chk("R2 rx msb first", rx_cfg_o, 12'h801);
      wr(4'h5, 12'hFF3);
      chk("R8 bias", pa_bias_o, 4'h3);
      chk("R3 rx untouched", rx_cfg_o, 12'h801);
   endtask

   task automatic t_long;
      // 20 bits: junk nibble 0xB then a receiver word
      ser_bits({12'h0, 4'hB, 4'h4, 12'h3C5}, 20, 1'b1);
      chk("R4 last16 rx", rx_cfg_o, 12'h3C5);
      chk("R4 synth kept", synth_o, 12'hC3E);
   endtask

   task automatic t_unmapped;
      wr(4'hF, 12'h000);
      wr(4'h0, 12'h777);
      wr(4'h6, 12'h001);
      chk("R5 enable", en_mask_o, 12'h5A6);
      chk("R5 synth", synth_o, 12'hC3E);
      chk("R5 chan", chan_o, 11);
      chk("R5 rx", rx_cfg_o, 12'h3C5);
      chk("R5 bias", pa_bias_o, 4'h3);
   endtask

   task automatic t_clamp;
      wr(4'h3, 12'd150);
      chk("R6 clamp chan", chan_o, 99);
      chk("R6 clamp mhz", chan_mhz_o, 2499);
      wr(4'h3, 12'd0);
      chk("R6 zero mhz", chan_mhz_o, 2400);
      wr(4'h3, 12'd99);
      chk("R6 top chan", chan_o, 99);
   endtask

   task automatic t_cs_idle;
      // clocks with select high must not shift
      @(negedge clk);
      for (int i = 0; i < 16; i++) begin
         sdi = 1'b1; sclk = 1'b1; wait_neg(4);
         sclk = 1'b0; wait_neg(4);
      end
      // empty frame recommits the last captured word (channel 99)
      @(negedge clk) cs_n = 1'b0;
      wait_neg(6);
      cs_n = 1'b1;
      wait_neg(8);
      chk("R2 idle clocks", chan_o, 99);
      chk("R2 idle rx", rx_cfg_o, 12'h3C5);
   endtask

   task automatic t_shutdown;
      @(negedge clk) shdn_n = 1'b0;
      @(negedge clk);
      chk("R7 mask gated", en_mask_o, 0);
      wr(4'h3, 12'd64);
      chk("R7 write in shdn", chan_o, 64);
      chk("R7 retain synth", synth_o, 12'hC3E);
      // new mask, commit and release in the same cycle
      ser_bits({16'h0, 4'h1, 12'hABC}, 16, 1'b0);
      @(negedge clk) cs_n = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk("R7 gated in flight", en_mask_o, 0);
      shdn_n = 1'b1;
      @(negedge clk);
      chk("R7 release with commit", en_mask_o, 12'hABC);
      wait_neg(4);
      chk("R7 retain bias", pa_bias_o, 4'h3);
   endtask

   initial begin
      wait_neg(5);
      rst_n = 1'b1;
      wait_neg(3);
      t_reset();
      t_basic();
      t_long();
      t_unmapped();
      t_clamp();
      t_cs_idle();
      t_shutdown();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule